// File: doc/BRIEF.md
# Microcode Control-Line Decoder

This block converts a stream of short micro-instructions into a bank of control lines for a microprogrammed I/O engine. Each instruction names a single control line and edits only that line. The other lines are left alone, so a control word is never supplied in full. There are two kinds of line. A load strobe is a register capture pulse: when it is raised it is high for exactly one cycle and then falls without a further instruction. This applies to every strobe, including one that captures the output bus back onto an input bus. A bus enable selects a driver onto a shared output bus. An enable is sticky, and raising it drops every other enable of the same bus group, so no bus ever has two drivers.

Per-line parameter masks decide the kind of each index, and a packed parameter gives each enable its bus-group number. Indices that are in neither mask are unused and have no effect. In the default level-field encoding, the word carries a line index and a level bit. A low level on an enable turns that enable off and leaves its bus undriven. In the compact select-only encoding there is no level bit: selecting a line pulses it if it is a strobe, or claims its bus if it is an enable. Both outputs are registered and take effect on the clock edge that samples a valid instruction.

Top module: `ucode_line_decoder`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) clears every bit of strobe_o and enable_o, whatever instruction is present at the same time.
- R2: An instruction acts only when mi_valid_i is high at a clock edge, and its effect is visible in the outputs right after that edge. With mi_valid_i low, strobe_o is all zero after the edge and enable_o is unchanged.
- R3: An instruction that raises a strobe line sets strobe_o at that line's bit for exactly one cycle. The bit then returns low with no further instruction. Raising the same strobe on consecutive valid cycles keeps it high for the same number of cycles. At most one strobe is high in any cycle.
- R4: An instruction that raises an enable line sets its enable_o bit. The bit stays high through any number of idle cycles until an instruction or a reset clears it.
- R5: Raising an enable clears every other enable of the same bus group and leaves other groups untouched, so at most one enable per group is high.
- R6: Level-field encoding: mi_word_i[5:0] is the line index and mi_word_i[6] is the level, where 1 means raise and 0 means lower. A low level on an enable clears only that enable, which leaves its bus undriven. A low level on a strobe or on an inactive enable changes nothing.
- R7: An instruction that names an unused index produces no strobe and leaves enable_o unchanged, whatever its level.
- R8: Default line map: indices 0 to 27 are strobes, 28 to 31 are unused, and 32 to 63 are enables. The bus group of an enable is index bits [4:3], which gives four groups of eight lines.
- R9: Select-only encoding (LEVEL_FIELD = 0): mi_word_i[5:0] is the index. Selecting a strobe pulses it. Selecting an enable raises it and clears the rest of its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mi_valid_i | input | 1 | Qualifies mi_word_i for this cycle |
| mi_word_i | input | INDEX_W+LEVEL_FIELD (7) | Micro-instruction: index, plus a level bit in the level-field encoding |
| strobe_o | output | LINE_COUNT (64) | Load-strobe pulses, one bit per line |
| enable_o | output | LINE_COUNT (64) | Sticky bus-driver enables, one bit per line |

## Verification
Each result is due one clock edge after the instruction is sampled. The bench drives a word on a falling edge and reads both vectors on the next falling edge, after the single register stage has updated. Strobe clearing is checked one further falling edge later, with valid low, and sticky enables are checked again after several idle cycles. Group claims and lowering are checked against whole 64-bit expected vectors, so a wrongly cleared line in another group is caught as well as a wrongly set one.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [1:0] {
      LINE_UNUSED = 2'd0,
      LINE_STROBE = 2'd1,
      LINE_ENABLE = 2'd2
   } line_kind_e;

   function automatic line_kind_e classify(input bit is_strobe, input bit is_enable);
      if (is_strobe)      return LINE_STROBE;
      else if (is_enable) return LINE_ENABLE;
      else                return LINE_UNUSED;
   endfunction

endpackage

// File: rtl/mcd_decode.sv
module mcd_decode
   import mcd_pkg::*;
#(
   parameter int                    LINE_COUNT  = 64,
   parameter int                    INDEX_W     = 6,
   parameter bit                    LEVEL_FIELD = 1'b1,
   parameter int                    WORD_W      = 7,
   parameter logic [LINE_COUNT-1:0] STROBE_MASK = '0,
   parameter logic [LINE_COUNT-1:0] ENABLE_MASK = '0
) (
   input  logic                  valid_i,
   input  logic [WORD_W-1:0]     word_i,
   output logic [LINE_COUNT-1:0] strobe_hit_o,
   output logic [LINE_COUNT-1:0] en_set_o,
   output logic [LINE_COUNT-1:0] en_clr_o
);

   logic [INDEX_W-1:0] idx;
   logic               raise;

   assign idx = word_i[INDEX_W-1:0];

   generate
      if (LEVEL_FIELD) begin : g_level
         assign raise = word_i[INDEX_W];
      end else begin : g_select
         assign raise = 1'b1;
      end
   endgenerate

   for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
      localparam line_kind_e KIND = classify(STROBE_MASK[i], ENABLE_MASK[i]);
      logic sel;
      assign sel = valid_i && (idx == INDEX_W'(i));
      if (KIND == LINE_STROBE) begin : g_strobe
         assign strobe_hit_o[i] = sel & raise;
         assign en_set_o[i]     = 1'b0;
         assign en_clr_o[i]     = 1'b0;
      end else if (KIND == LINE_ENABLE) begin : g_enable
         assign strobe_hit_o[i] = 1'b0;
         assign en_set_o[i]     = sel & raise;
         assign en_clr_o[i]     = sel & ~raise;
      end else begin : g_unused
         assign strobe_hit_o[i] = 1'b0;
         assign en_set_o[i]     = 1'b0;
         assign en_clr_o[i]     = 1'b0;
      end
   end

endmodule

// File: rtl/mcd_strobe_bank.sv
module mcd_strobe_bank #(
   parameter int LINE_COUNT = 64
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic [LINE_COUNT-1:0] hit_i,
   output logic [LINE_COUNT-1:0] strobe_o
);

   logic [LINE_COUNT-1:0] pulse_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) pulse_q <= '0;
      else       pulse_q <= hit_i;
   end

   assign strobe_o = pulse_q;

   // R3: a pulse that is not requested again is gone on the next cycle
   p_pulse_drops_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_q != '0 && hit_i == '0) |=> (pulse_q == '0));

endmodule

// File: rtl/mcd_enable_bank.sv
module mcd_enable_bank #(
   parameter int                            LINE_COUNT  = 64,
   parameter int                            GROUP_COUNT = 4,
   parameter int                            GROUP_W     = 2,
   parameter logic [LINE_COUNT-1:0]         ENABLE_MASK = '0,
   parameter logic [LINE_COUNT*GROUP_W-1:0] GROUP_MAP   = '0
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic [LINE_COUNT-1:0] set_i,
   input  logic [LINE_COUNT-1:0] clr_i,
   output logic [LINE_COUNT-1:0] enable_o
);

   logic [LINE_COUNT-1:0] member [GROUP_COUNT];
   logic [LINE_COUNT-1:0] claim_clear [GROUP_COUNT];
   logic [LINE_COUNT-1:0] clear_mask;
   logic [LINE_COUNT-1:0] en_q;

   for (genvar i = 0; i < LINE_COUNT; i++) begin : g_chk
      if (ENABLE_MASK[i] && (int'(GROUP_MAP[i*GROUP_W +: GROUP_W]) >= GROUP_COUNT)) begin : g_bad
         $error("enable line %0d names a bus group beyond GROUP_COUNT", i);
      end
   end

   for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_group
      for (genvar i = 0; i < LINE_COUNT; i++) begin : g_mem
         assign member[g][i] = ENABLE_MASK[i] &&
                               (GROUP_MAP[i*GROUP_W +: GROUP_W] == GROUP_W'(g));
      end
      assign claim_clear[g] = (|(set_i & member[g])) ? member[g] : '0;

      // R5: one driver per bus group at most
      p_one_driver_r5: assert property (@(posedge clk_i) disable iff (rst_i)
         $onehot0(en_q & member[g]));
   end

   always_comb begin
      clear_mask = clr_i;
      for (int g = 0; g < GROUP_COUNT; g++) clear_mask |= claim_clear[g];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) en_q <= '0;
      else       en_q <= (en_q & ~clear_mask) | set_i;
   end

   assign enable_o = en_q;

   // R4: an enable with no request against it survives the edge
   p_sticky_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (set_i == '0 && clr_i == '0) |=> $stable(en_q));

endmodule

// File: rtl/ucode_line_decoder.sv
module ucode_line_decoder
   import mcd_pkg::*;
#(
   parameter int                            LINE_COUNT  = 64,
   parameter int                            INDEX_W     = 6,
   parameter bit                            LEVEL_FIELD = 1'b1,
   parameter int                            GROUP_COUNT = 4,
   parameter int                            GROUP_W     = 2,
   parameter logic [LINE_COUNT-1:0]         STROBE_MASK = 64'h0000_0000_0FFF_FFFF,
   parameter logic [LINE_COUNT-1:0]         ENABLE_MASK = 64'hFFFF_FFFF_0000_0000,
   parameter logic [LINE_COUNT*GROUP_W-1:0] GROUP_MAP   =
      {16'hFFFF, 16'hAAAA, 16'h5555, 16'h0000, 64'h0}
) (
   input  logic                                 clk_i,
   input  logic                                 rst_i,
   input  logic                                 mi_valid_i,
   input  logic [INDEX_W+int'(LEVEL_FIELD)-1:0] mi_word_i,
   output logic [LINE_COUNT-1:0]                strobe_o,
   output logic [LINE_COUNT-1:0]                enable_o
);

   localparam int WORD_W = INDEX_W + int'(LEVEL_FIELD);

   generate
      if (LINE_COUNT < 2 || LINE_COUNT > 256) begin : g_bad_count
         $error("LINE_COUNT must lie in 2..256");
      end
      if (INDEX_W != $clog2(LINE_COUNT)) begin : g_bad_index
         $error("INDEX_W must equal clog2(LINE_COUNT)");
      end
      if ((STROBE_MASK & ENABLE_MASK) != '0) begin : g_bad_overlap
         $error("a line cannot be both strobe and enable");
      end
      if (GROUP_COUNT < 1 || GROUP_COUNT > (1 << GROUP_W)) begin : g_bad_groups
         $error("GROUP_COUNT does not fit GROUP_W");
      end
   endgenerate

   logic [LINE_COUNT-1:0] strobe_hit;
   logic [LINE_COUNT-1:0] en_set;
   logic [LINE_COUNT-1:0] en_clr;

   mcd_decode #(
      .LINE_COUNT (LINE_COUNT),
      .INDEX_W    (INDEX_W),
      .LEVEL_FIELD(LEVEL_FIELD),
      .WORD_W     (WORD_W),
      .STROBE_MASK(STROBE_MASK),
      .ENABLE_MASK(ENABLE_MASK)
   ) u_decode (
      .valid_i     (mi_valid_i),
      .word_i      (mi_word_i),
      .strobe_hit_o(strobe_hit),
      .en_set_o    (en_set),
      .en_clr_o    (en_clr)
   );

   mcd_strobe_bank #(
      .LINE_COUNT(LINE_COUNT)
   ) u_strobe (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .hit_i   (strobe_hit),
      .strobe_o(strobe_o)
   );

   mcd_enable_bank #(
      .LINE_COUNT (LINE_COUNT),
      .GROUP_COUNT(GROUP_COUNT),
      .GROUP_W    (GROUP_W),
      .ENABLE_MASK(ENABLE_MASK),
      .GROUP_MAP  (GROUP_MAP)
   ) u_enable (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .set_i   (en_set),
      .clr_i   (en_clr),
      .enable_o(enable_o)
   );

   // Port-level checks
   logic [INDEX_W-1:0] word_idx;
   logic               idx_unused;
   logic               idx_enable;

   assign word_idx   = mi_word_i[INDEX_W-1:0];
   assign idx_unused = (int'(word_idx) >= LINE_COUNT) ||
                       !(STROBE_MASK[word_idx] || ENABLE_MASK[word_idx]);
   assign idx_enable = (int'(word_idx) < LINE_COUNT) && ENABLE_MASK[word_idx];

   // R1: the cycle after a reset edge shows every line low
   p_reset_clear_r1: assert property (@(posedge clk_i)
      $past(rst_i) |-> (strobe_o == '0 && enable_o == '0));

   // R2: no valid, no pulse and no enable change
   p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !mi_valid_i |=> (strobe_o == '0 && $stable(enable_o)));

   // R3: a strobe is only ever the answer to a valid instruction, one at a time
   p_strobe_cause_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (strobe_o != '0) |-> ($past(mi_valid_i) && $countones(strobe_o) == 1));

   // R7: unused indices touch nothing
   p_unused_noop_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (mi_valid_i && idx_unused) |=> (strobe_o == '0 && $stable(enable_o)));

   generate
      if (LEVEL_FIELD) begin : g_lower_chk
         // R6: a low level on an enable leaves that line low
         p_lower_clears_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (mi_valid_i && idx_enable && !mi_word_i[INDEX_W])
               |=> (enable_o[$past(word_idx)] == 1'b0));
      end
   endgenerate

endmodule

// File: tb/ucode_line_decoder_bench.sv
module ucode_line_decoder_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        lv_valid = 1'b0;
   logic [6:0]  lv_word  = '0;
   logic        sl_valid = 1'b0;
   logic [5:0]  sl_word  = '0;
   logic [63:0] lv_strobe, lv_enable, sl_strobe, sl_enable;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   ucode_line_decoder u_ucode_line_decoder (
      .clk_i(clk), .rst_i(rst), .mi_valid_i(lv_valid), .mi_word_i(lv_word),
      .strobe_o(lv_strobe), .enable_o(lv_enable));

   ucode_line_decoder #(.LEVEL_FIELD(1'b0)) u_ucode_line_decoder_sel (
      .clk_i(clk), .rst_i(rst), .mi_valid_i(sl_valid), .mi_word_i(sl_word),
      .strobe_o(sl_strobe), .enable_o(sl_enable));

   function automatic logic [63:0] bit_at(input int n);
      return 64'd1 << n;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // present one level-field instruction, return after the outputs show it
   task automatic put(input int idx, input bit lvl);
      lv_valid = 1'b1;
      lv_word  = {lvl, 6'(idx)};
      @(negedge clk);
      lv_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 strobes after reset", lv_strobe, 64'd0);
      check("R1 enables after reset", lv_enable, 64'd0);
   endtask

   task automatic t_strobe_pulse();
      put(5, 1'b1);
      check("R3/R8 strobe 5 raised", lv_strobe, bit_at(5));
      idle(1);
      check("R3 strobe 5 self-cleared", lv_strobe, 64'd0);
      put(27, 1'b1);
      check("R8 highest strobe 27", lv_strobe, bit_at(27));
      idle(1);
   endtask

   task automatic t_back_to_back();
      lv_valid = 1'b1;
      lv_word  = {1'b1, 6'd3};
      @(negedge clk);
      check("R3 back-to-back first", lv_strobe, bit_at(3));
      @(negedge clk);
      check("R3 back-to-back second", lv_strobe, bit_at(3));
      lv_word = {1'b1, 6'd0};
      @(negedge clk);
      check("R3 line change", lv_strobe, bit_at(0));
      lv_valid = 1'b0;
      @(negedge clk);
      check("R3 cleared after run", lv_strobe, 64'd0);
   endtask

   task automatic t_strobe_low();
      put(7, 1'b0);
      check("R6 low level on strobe", lv_strobe, 64'd0);
      check("R6 low on strobe leaves enables", lv_enable, 64'd0);
   endtask

   task automatic t_sticky();
      put(33, 1'b1);
      check("R4 enable 33 raised", lv_enable, bit_at(33));
      idle(5);
      check("R4 enable 33 sticky", lv_enable, bit_at(33));
   endtask

   task automatic t_exclusive();
      put(35, 1'b1);
      check("R5 claim 35 drops 33", lv_enable, bit_at(35));
      put(41, 1'b1);
      check("R5 other group kept", lv_enable, bit_at(35) | bit_at(41));
      put(56, 1'b1);
      put(63, 1'b1);
      check("R5/R8 group3 claim", lv_enable, bit_at(35) | bit_at(41) | bit_at(63));
      put(39, 1'b1);
      check("R8 group0 edge line 39", lv_enable, bit_at(39) | bit_at(41) | bit_at(63));
   endtask

   task automatic t_lower();
      put(39, 1'b0);
      check("R6 lower 39 bus undriven", lv_enable, bit_at(41) | bit_at(63));
      put(44, 1'b0);
      check("R6 lower inactive 44", lv_enable, bit_at(41) | bit_at(63));
   endtask

   task automatic t_unused();
      put(29, 1'b1);
      check("R7 unused 29 strobe", lv_strobe, 64'd0);
      check("R7 unused 29 enables", lv_enable, bit_at(41) | bit_at(63));
      put(31, 1'b0);
      check("R7 unused 31 low", lv_enable, bit_at(41) | bit_at(63));
   endtask

   task automatic t_valid_low();
      lv_valid = 1'b0;
      lv_word  = {1'b1, 6'd10};
      @(negedge clk);
      check("R2 no strobe without valid", lv_strobe, 64'd0);
      lv_word = {1'b1, 6'd42};
      @(negedge clk);
      check("R2 no enable without valid", lv_enable, bit_at(41) | bit_at(63));
   endtask

   task automatic t_reset_mid();
      rst      = 1'b1;
      lv_valid = 1'b1;
      lv_word  = {1'b1, 6'd12};
      @(negedge clk);
      check("R1 reset beats strobe", lv_strobe, 64'd0);
      check("R1 reset clears enables", lv_enable, 64'd0);
      rst      = 1'b0;
      lv_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_select();
      sl_valid = 1'b1;
      sl_word  = 6'd40;
      @(negedge clk);
      check("R9 select raises 40", sl_enable, bit_at(40));
      sl_word = 6'd44;
      @(negedge clk);
      check("R9 select 44 drops 40", sl_enable, bit_at(44));
      sl_word = 6'd2;
      @(negedge clk);
      check("R9 select pulses 2", sl_strobe, bit_at(2));
      sl_valid = 1'b0;
      @(negedge clk);
      check("R9 pulse gone, enable kept", sl_strobe | sl_enable, bit_at(44));
   endtask

   initial begin
      idle(3);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_strobe_pulse();
      t_back_to_back();
      t_strobe_low();
      t_sticky();
      t_exclusive();
      t_lower();
      t_unused();
      t_valid_low();
      t_reset_mid();
      t_select();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule